// File: doc/BRIEF.md
# Straddling Access Splitter and Region Checker

This block takes one memory access (a load, a store or an instruction fetch of 1, 2, 4 or 8 bytes) and checks it against a table of eight address regions. Each region carries read, write and execute permission bits and a smallest allowed access width. Regions are described in whole 4 KiB pages, so one lookup per page is enough.

An access that lies inside one page is checked as a single part. An access whose last byte falls in the next page is cut at that page edge into two parts. Each part is looked up and judged on its own, and gets its own byte count, start address, pass bit and fault code. One half of a straddling store can therefore be allowed while the other half faults. The results appear one clock after the request. The memory operation itself is not performed here.

Top module: `straddle_guard`

## Requirements
- R1: While reset is asserted and right after it, `outValid`, `out0Pass` and `out1Pass` are 0.
- R2: The outputs for a request presented with `reqValid` high are valid, with `outValid` high, on the next clock edge. `outValid` is low one edge after `reqValid` is low.
- R3: Size code `reqSize` n means 2^n bytes. If the first and last byte share a 4 KiB page, `outSplit` is 0. Part 0 then has the request address and the full byte count. Part 1 has zero bytes, `out1Pass` 0 and fault code 0.
- R4: If the last byte falls in the next page, `outSplit` is 1. Part 0 runs from the request address to the page end (4096 minus the offset in the page). Part 1 starts at the next page base and holds the remaining bytes.
- R5: Region k covers page number p (address bits 31:12) when `regBase` slice k <= p <= `regLimit` slice k. Where several regions cover a page, the lowest k decides.
- R6: A part whose page is covered by no region gets fault code 3 (no region).
- R7: Access kind 0 is a load and needs permission bit 0. Kind 1 is a store and needs bit 1. Kind 2 is a fetch and needs bit 2. Kind 3 never passes. A missing bit gives fault code 1 (permission). It takes priority over the width fault.
- R8: Region width field w (2 bits) forbids parts shorter than 2^w bytes, with fault code 2 (width). The part's own byte count is what is compared.
- R9: The two parts of a split access are judged independently, so one may pass while the other faults.
- R10: For every active part, the pass bit is 1 exactly when the fault code is 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Byte address of the first byte |
| reqSize | input | 2 | Size code: 2^n bytes |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| regBase | input | 160 | Eight 20-bit first page numbers, region k at bits 20k+19:20k |
| regLimit | input | 160 | Eight 20-bit last page numbers (inclusive) |
| regPerm | input | 24 | Eight 3-bit permissions: bit0 read, bit1 write, bit2 execute |
| regMinW | input | 16 | Eight 2-bit smallest width codes |
| outValid | output | 1 | Results valid |
| outSplit | output | 1 | Access was cut at a page edge |
| out0Addr | output | 32 | Start address of part 0 |
| out0Bytes | output | 4 | Byte count of part 0 |
| out0Pass | output | 1 | Part 0 allowed |
| out0Fault | output | 2 | Part 0 fault: 0 none, 1 permission, 2 width, 3 no region |
| out1Addr | output | 32 | Start address of part 1 |
| out1Bytes | output | 4 | Byte count of part 1 |
| out1Pass | output | 1 | Part 1 allowed |
| out1Fault | output | 2 | Part 1 fault code |

## Verification
Every result of this block passes through exactly one register, so every output is due one clock edge after the request. The bench drives a request at a falling edge and reads all outputs at the next falling edge, half a period after the edge that captured them. A cycle with `reqValid` low is checked in the same way, one edge later. The sweep covers page offsets on both sides of a page edge, all sizes and kinds, and pages with overlapping, missing, narrow and execute-only regions.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int ADDR_W    = 32;
  localparam int PAGE_BITS = 12;
  localparam int PAGE_W    = ADDR_W - PAGE_BITS;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_PERM   = 2'd1,
    FLT_WIDTH  = 2'd2,
    FLT_NOREG  = 2'd3
  } faultT;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kindT;

  // strobes from the split control to the lookup datapath
  typedef struct packed {
    logic              split;
    logic              part1En;
    logic [3:0]        bytes0;
    logic [3:0]        bytes1;
    logic [PAGE_W-1:0] page0;
    logic [PAGE_W-1:0] page1;
  } ctrlT;
endpackage

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
(
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output ctrlT              ctrl
);
  localparam int OFF_W = PAGE_BITS + 1;
  localparam logic [OFF_W-1:0] PAGE_SPAN = OFF_W'(1) << PAGE_BITS;

  logic [OFF_W-1:0] offset;
  logic [OFF_W-1:0] totalBytes;
  logic [OFF_W-1:0] lastOff;
  logic [OFF_W-1:0] firstPart;
  logic             crosses;

  always_comb begin
    offset     = {1'b0, reqAddr[PAGE_BITS-1:0]};
    totalBytes = OFF_W'(1) << reqSize;
    lastOff    = offset + totalBytes - OFF_W'(1);
    crosses    = lastOff[PAGE_BITS];
    firstPart  = crosses ? (PAGE_SPAN - offset) : totalBytes;

    ctrl.split   = crosses;
    ctrl.part1En = crosses;
    ctrl.bytes0  = firstPart[3:0];
    ctrl.bytes1  = crosses ? 4'(totalBytes - firstPart) : 4'd0;
    ctrl.page0   = reqAddr[ADDR_W-1:PAGE_BITS];
    ctrl.page1   = reqAddr[ADDR_W-1:PAGE_BITS] + PAGE_W'(1);
  end
endmodule

// File: rtl/sg_lookup.sv
module sg_lookup
  import sg_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                          enable,
  input  logic [PAGE_W-1:0]             page,
  input  logic [1:0]                    kind,
  input  logic [3:0]                    bytes,
  input  logic [NUM_REGIONS*PAGE_W-1:0] regBase,
  input  logic [NUM_REGIONS*PAGE_W-1:0] regLimit,
  input  logic [NUM_REGIONS*3-1:0]      regPerm,
  input  logic [NUM_REGIONS*2-1:0]      regMinW,
  output logic                          pass,
  output logic [1:0]                    fault
);
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic [NUM_REGIONS-1:0] match;

  for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_match
    assign match[k] = (page >= regBase[k*PAGE_W +: PAGE_W]) &&
                      (page <= regLimit[k*PAGE_W +: PAGE_W]);
  end

  logic             hit;
  logic [IDX_W-1:0] winIdx;
  logic [2:0]       winPerm;
  logic [1:0]       winMinW;
  logic             permOk;
  logic [4:0]       minBytes;

  always_comb begin
    hit    = 1'b0;
    winIdx = '0;
    for (int k = NUM_REGIONS - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit    = 1'b1;
        winIdx = IDX_W'(k);
      end
    end
    winPerm  = regPerm[winIdx*3 +: 3];
    winMinW  = regMinW[winIdx*2 +: 2];
    minBytes = 5'd1 << winMinW;
    case (kindT'(kind))
      KIND_LOAD:  permOk = winPerm[0];
      KIND_STORE: permOk = winPerm[1];
      KIND_FETCH: permOk = winPerm[2];
      default:    permOk = 1'b0;
    endcase

    if (!enable)                    fault = FLT_NONE;
    else if (!hit)                  fault = FLT_NOREG;
    else if (!permOk)               fault = FLT_PERM;
    else if ({1'b0, bytes} < minBytes) fault = FLT_WIDTH;
    else                            fault = FLT_NONE;
    pass = enable && (fault == FLT_NONE);
  end
endmodule

// File: rtl/straddle_guard.sv
module straddle_guard
  import sg_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [1:0]                    reqSize,
  input  logic [1:0]                    reqKind,
  input  logic [NUM_REGIONS*PAGE_W-1:0] regBase,
  input  logic [NUM_REGIONS*PAGE_W-1:0] regLimit,
  input  logic [NUM_REGIONS*3-1:0]      regPerm,
  input  logic [NUM_REGIONS*2-1:0]      regMinW,
  output logic                          outValid,
  output logic                          outSplit,
  output logic [ADDR_W-1:0]             out0Addr,
  output logic [3:0]                    out0Bytes,
  output logic                          out0Pass,
  output logic [1:0]                    out0Fault,
  output logic [ADDR_W-1:0]             out1Addr,
  output logic [3:0]                    out1Bytes,
  output logic                          out1Pass,
  output logic [1:0]                    out1Fault
);
  localparam int NUM_PARTS = 2;

  ctrlT ctrl;

  sg_ctrl u_ctrl (
    .reqAddr (reqAddr),
    .reqSize (reqSize),
    .ctrl    (ctrl)
  );

  logic [NUM_PARTS-1:0]        partEn;
  logic [PAGE_W-1:0]           partPage  [NUM_PARTS];
  logic [3:0]                  partBytes [NUM_PARTS];
  logic [NUM_PARTS-1:0]        partPass;
  logic [1:0]                  partFault [NUM_PARTS];

  assign partEn       = {ctrl.part1En, 1'b1};
  assign partPage[0]  = ctrl.page0;
  assign partPage[1]  = ctrl.page1;
  assign partBytes[0] = ctrl.bytes0;
  assign partBytes[1] = ctrl.bytes1;

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    sg_lookup #(.NUM_REGIONS(NUM_REGIONS)) u_lookup (
      .enable   (partEn[p]),
      .page     (partPage[p]),
      .kind     (reqKind),
      .bytes    (partBytes[p]),
      .regBase  (regBase),
      .regLimit (regLimit),
      .regPerm  (regPerm),
      .regMinW  (regMinW),
      .pass     (partPass[p]),
      .fault    (partFault[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      outSplit  <= 1'b0;
      out0Addr  <= '0;
      out0Bytes <= '0;
      out0Pass  <= 1'b0;
      out0Fault <= FLT_NONE;
      out1Addr  <= '0;
      out1Bytes <= '0;
      out1Pass  <= 1'b0;
      out1Fault <= FLT_NONE;
    end else begin
      outValid <= reqValid;
      if (reqValid) begin
        outSplit  <= ctrl.split;
        out0Addr  <= reqAddr;
        out0Bytes <= partBytes[0];
        out0Pass  <= partPass[0];
        out0Fault <= partFault[0];
        out1Addr  <= ctrl.split ? {ctrl.page1, {PAGE_BITS{1'b0}}} : '0;
        out1Bytes <= partBytes[1];
        out1Pass  <= partPass[1];
        out1Fault <= partFault[1];
      end
    end
  end

  // R2: one register between request and result
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> outValid);

  // R3: an unsplit access leaves part 1 empty
  a_r3_part1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outSplit) |-> (out1Bytes == 4'd0 && !out1Pass && out1Fault == 2'd0));

  // R4: a split lands exactly on a page edge
  a_r4_split_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outSplit) |->
      (out1Addr[PAGE_BITS-1:0] == '0 &&
       ({1'b0, out0Addr[PAGE_BITS-1:0]} + 13'(out0Bytes)) == 13'h1000));

  // R4: the two parts together hold every byte of the request
  a_r4_byte_total: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reqValid) |-> ({1'b0, out0Bytes} + {1'b0, out1Bytes} == (5'd1 << $past(reqSize))));
endmodule

// File: tb/straddle_guard_bench.sv
module straddle_guard_bench;
  localparam int NR = 8;
  localparam int PW = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic             reqValid;
  logic [31:0]      reqAddr;
  logic [1:0]       reqSize;
  logic [1:0]       reqKind;
  logic [NR*PW-1:0] regBase;
  logic [NR*PW-1:0] regLimit;
  logic [NR*3-1:0]  regPerm;
  logic [NR*2-1:0]  regMinW;
  logic             outValid, outSplit, out0Pass, out1Pass;
  logic [31:0]      out0Addr, out1Addr;
  logic [3:0]       out0Bytes, out1Bytes;
  logic [1:0]       out0Fault, out1Fault;

  straddle_guard u_straddle_guard (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqKind(reqKind), .regBase(regBase), .regLimit(regLimit),
    .regPerm(regPerm), .regMinW(regMinW), .outValid(outValid), .outSplit(outSplit),
    .out0Addr(out0Addr), .out0Bytes(out0Bytes), .out0Pass(out0Pass), .out0Fault(out0Fault),
    .out1Addr(out1Addr), .out1Bytes(out1Bytes), .out1Pass(out1Pass), .out1Fault(out1Fault)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int mixedSplits = 0;

  logic [19:0] tBase [NR];
  logic [19:0] tLim  [NR];
  logic [2:0]  tPerm [NR];
  logic [1:0]  tMinW [NR];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, logic [31:0] addr);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%0h expected=%0h", tag, addr, act, exp);
    end
  endtask

  function automatic logic [1:0] refFault(logic [19:0] page, logic [1:0] kind, int nbytes);
    for (int k = 0; k < NR; k++) begin
      if (page >= tBase[k] && page <= tLim[k]) begin
        if (kind == 2'd3 || !tPerm[k][kind]) return 2'd1;
        if (nbytes < (1 << tMinW[k])) return 2'd2;
        return 2'd0;
      end
    end
    return 2'd3;
  endfunction

  function automatic string faultTag(logic [1:0] f);
    case (f)
      2'd0: return "R5";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic runOne(logic [31:0] addr, logic [1:0] size, logic [1:0] kind);
    int total, off, b0, b1;
    bit sp;
    logic [19:0] pg1;
    logic [1:0] f0, f1;
    total = 1 << size;
    off   = int'(addr[11:0]);
    sp    = (off + total) > 4096;
    b0    = sp ? 4096 - off : total;
    b1    = total - b0;
    pg1   = addr[31:12] + 20'd1;
    f0    = refFault(addr[31:12], kind, b0);
    f1    = sp ? refFault(pg1, kind, b1) : 2'd0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqSize = size; reqKind = kind;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 valid", 64'(outValid), 64'd1, addr);
    chk(sp ? "R4 split" : "R3 split", 64'(outSplit), 64'(sp), addr);
    chk("R3 addr0", 64'(out0Addr), 64'(addr), addr);
    chk(sp ? "R4 bytes0" : "R3 bytes0", 64'(out0Bytes), 64'(b0), addr);
    chk(sp ? "R4 bytes1" : "R3 bytes1", 64'(out1Bytes), 64'(b1), addr);
    if (sp) chk("R4 addr1", 64'(out1Addr), 64'({pg1, 12'h000}), addr);
    chk(faultTag(f0), 64'(out0Fault), 64'(f0), addr);
    chk(sp ? faultTag(f1) : "R3 fault1", 64'(out1Fault), 64'(f1), addr);
    chk("R10 pass0", 64'(out0Pass), 64'(f0 == 2'd0), addr);
    chk("R10 pass1", 64'(out1Pass), 64'(sp && f1 == 2'd0), addr);
    if (sp && ((f0 == 2'd0) != (f1 == 2'd0))) mixedSplits++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int offs [14] = '{0, 1, 2, 3, 4, 6, 4088, 4089, 4090, 4091, 4092, 4093, 4094, 4095};
    for (int k = 0; k < NR; k++) begin
      tBase[k] = 20'hFFFFF; tLim[k] = 20'h0; tPerm[k] = 3'd0; tMinW[k] = 2'd0;
    end
    // R5: region 0 overlaps region 1 on page 0x10 and wins there
    tBase[0] = 20'h10; tLim[0] = 20'h10; tPerm[0] = 3'b001; tMinW[0] = 2'd0;
    tBase[1] = 20'h10; tLim[1] = 20'h13; tPerm[1] = 3'b011; tMinW[1] = 2'd2;
    tBase[2] = 20'h14; tLim[2] = 20'h14; tPerm[2] = 3'b111; tMinW[2] = 2'd0;
    tBase[3] = 20'h16; tLim[3] = 20'h16; tPerm[3] = 3'b100; tMinW[3] = 2'd3;
    for (int k = 0; k < NR; k++) begin
      regBase[k*PW +: PW]  = tBase[k];
      regLimit[k*PW +: PW] = tLim[k];
      regPerm[k*3 +: 3]    = tPerm[k];
      regMinW[k*2 +: 2]    = tMinW[k];
    end
    rst_n = 1'b0; reqValid = 1'b0; reqAddr = '0; reqSize = '0; reqKind = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid", 64'(outValid), 64'd0, 32'd0);
    chk("R1 pass", 64'({out0Pass, out1Pass}), 64'd0, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after", 64'(outValid), 64'd0, 32'd0);

    for (int pg = 'h0F; pg <= 'h17; pg++)
      for (int oi = 0; oi < 14; oi++)
        for (int sz = 0; sz < 4; sz++)
          for (int kd = 0; kd < 4; kd++)
            runOne({20'(pg), 12'(offs[oi])}, 2'(sz), 2'(kd));

    @(negedge clk);
    chk("R2 idle", 64'(outValid), 64'd0, 32'd0);
    chk("R9 mixed", 64'(mixedSplits > 0), 64'd1, 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule